// File: doc/BRIEF.md
# Direct-Mapped Second-Level Cache Tag Controller

This block holds the tags of a direct-mapped second-level cache and decides, for each physical address it is given, whether the access hits, whether the address is cacheable at all, and which memory operations must follow. Each line has exactly one tag byte in an internal synchronous tag memory. A separate valid bit per line sits beside it. The data memory and the system bus are outside the block. The block sees them only through two request/acknowledge pairs: one that writes a victim line back, and one that fills a line.

The tag byte is read in one of three ways, chosen by a mode input. In write-through mode all eight bits are tag, so the cacheable window is as large as possible. In split write-back mode the top bit is a dirty flag and seven bits are tag, so the window is half as large. In all-dirty write-back mode all eight bits are tag, and every valid line counts as modified when it is replaced. With 16-byte lines and `IDX_W = 15` (32K lines, 512 KB of data) the windows are 128 MB and 64 MB. The default elaboration uses `IDX_W = 6` (64 lines), which keeps the arrays small. Every width follows from the parameters.

A flush input clears the valid bits one line per clock. Software changes the mode only while the block is idle, followed by a flush.

Top module: `l2_tag_ctrl`

## Requirements
- R1: A strobe (`req_valid` high while `busy` is low and `flush` is low) is captured at a clock edge. `busy` is high from the next cycle on. `resp_valid` is a one-cycle pulse after the second rising edge counted from the capturing edge. A hit or a non-cacheable access returns `busy` low in that same cycle.
- R2: The tag field begins at address bit `OFS_W+IDX_W`. An access is cacheable only if every address bit at or above `OFS_W+IDX_W+T` is zero. T is 7 in split mode and 8 otherwise. A non-cacheable access reports `resp_cacheable=0` and `resp_hit=0`, raises neither `wb_req` nor `fill_req`, and leaves the stored tags unchanged.
- R3: Mode encoding is 0 = write-through, 1 = split write-back (bit 7 of the tag byte is dirty, bits 6:0 are tag), 2 = all-dirty write-back, and 3 behaves as 0. A cacheable access hits when the line's valid bit is set and the stored tag equals the address tag over T bits.
- R4: A cacheable miss whose victim is not dirty raises `fill_req` with `fill_addr` equal to the request address with the low `OFS_W` bits cleared. The request is held until `fill_ack`. At that point the line becomes valid with the new tag, so the next access to that address hits.
- R5: In split mode a write hit sets the line's dirty flag, and a write miss installs the line already dirty. A miss to a valid dirty line first raises `wb_req` alone. `wb_addr` is the stored tag placed at the tag position plus the index, with offset bits zero. After `wb_ack` the block raises `fill_req`.
- R6: In all-dirty mode a miss to any valid line produces a write-back of the victim before the fill, following the R5 sequence.
- R7: In write-through mode `wb_req` never rises. A cacheable write raises `mem_wr` in the same cycle as its `resp_valid`, whether it hits or misses. `mem_wr` stays low in both write-back modes.
- R8: A `flush` seen while idle keeps `busy` high for exactly 2^IDX_W cycles and invalidates every line. Strobes during the flush are ignored and produce no response.
- R9: After reset, `busy`, `resp_valid`, `mem_wr`, `wb_req` and `fill_req` are low, and every line is invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | Tag byte interpretation (R3 encoding) |
| flush | input | 1 | Start invalidating all lines |
| req_valid | input | 1 | Access strobe |
| req_write | input | 1 | Access is a write |
| req_addr | input | ADDR_W | Physical address |
| busy | output | 1 | Lookup, miss handling or flush in progress |
| resp_valid | output | 1 | Lookup result pulse |
| resp_hit | output | 1 | Access hit |
| resp_cacheable | output | 1 | Address is inside the cacheable window |
| mem_wr | output | 1 | Write-through memory write pulse |
| wb_req | output | 1 | Victim write-back request |
| wb_addr | output | ADDR_W | Victim line address |
| wb_ack | input | 1 | Write-back done |
| fill_req | output | 1 | Line fill request |
| fill_addr | output | ADDR_W | Line address to fill |
| fill_ack | input | 1 | Fill done |

## Verification
The assertions check the handshake rules on every cycle:
- requests are held with stable addresses until acknowledged;
- write-back and fill are never raised together;
- a fill follows every acknowledged write-back;
- each captured strobe yields a single response pulse;
- a non-cacheable or write-through access never starts a write-back.

Only the bench's scenarios can show that tags are compared over the right number of bits and that the cacheable boundary moves with the mode. They also show that victim addresses are rebuilt correctly and that the dirty state follows writes. For these the bench sweeps every line in every mode against its own model of the tag store.

// File: rtl/l2tc_pkg.sv
package l2tc_pkg;

    localparam logic [1:0] MODE_WT       = 2'd0;
    localparam logic [1:0] MODE_SPLIT    = 2'd1;
    localparam logic [1:0] MODE_ALLDIRTY = 2'd2;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_WB,
        ST_FILL,
        ST_FLUSH
    } ctl_state_e;

    typedef struct packed {
        logic hit;
        logic victim_dirty;
    } lookup_t;

    function automatic logic mode_split(input logic [1:0] m);
        return m == MODE_SPLIT;
    endfunction

    function automatic logic mode_writethrough(input logic [1:0] m);
        return (m != MODE_SPLIT) && (m != MODE_ALLDIRTY);
    endfunction

    // A valid line is dirty if its flag is set (split) or always (all-dirty).
    function automatic logic victim_dirty(input logic [1:0] m, input logic vbit,
                                          input logic flag);
        if (!vbit)               return 1'b0;
        if (m == MODE_SPLIT)     return flag;
        if (m == MODE_ALLDIRTY)  return 1'b1;
        return 1'b0;
    endfunction

endpackage

// File: rtl/l2tc_addr_decode.sv
module l2tc_addr_decode #(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              split,
    output logic [IDX_W-1:0]  idx,
    output logic [TAG_W-1:0]  tag,
    output logic              cacheable
);
    localparam int LINE_LO = OFS_W + IDX_W;
    localparam int HI_FULL = LINE_LO + TAG_W;

    assign idx = addr[LINE_LO-1:OFS_W];
    assign tag = addr[LINE_LO +: TAG_W];

    always_comb begin
        if (split) cacheable = (addr >> (HI_FULL - 1)) == '0;
        else       cacheable = (addr >> HI_FULL) == '0;
    end
endmodule

// File: rtl/l2tc_tag_ram.sv
module l2tc_tag_ram #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data
);
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/l2tc_valid_array.sv
module l2tc_valid_array #(
    parameter int DEPTH = 64,
    parameter int AW    = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_en,
    input  logic [AW-1:0] clr_idx,
    input  logic          set_en,
    input  logic [AW-1:0] set_idx,
    input  logic [AW-1:0] rd_idx,
    output logic          rd_valid
);
    logic [DEPTH-1:0] vbits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vbits_q <= '0;
        end else begin
            if (clr_en) vbits_q[clr_idx] <= 1'b0;
            if (set_en) vbits_q[set_idx] <= 1'b1;
        end
    end

    assign rd_valid = vbits_q[rd_idx];
endmodule

// File: rtl/l2_tag_ctrl.sv
module l2_tag_ctrl
    import l2tc_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int OFS_W  = 4,
    parameter int IDX_W  = 6,
    parameter int TAG_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              flush,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              busy,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_cacheable,
    output logic              mem_wr,
    output logic              wb_req,
    output logic [ADDR_W-1:0] wb_addr,
    input  logic              wb_ack,
    output logic              fill_req,
    output logic [ADDR_W-1:0] fill_addr,
    input  logic              fill_ack
);
    localparam int DEPTH   = 1 << IDX_W;
    localparam int LINE_LO = OFS_W + IDX_W;
    localparam int PAD_W   = ADDR_W - LINE_LO - TAG_W;

    ctl_state_e        state_q;
    logic [ADDR_W-1:0] addr_q;
    logic              write_q;
    logic [IDX_W-1:0]  flush_cnt_q;

    logic              split;
    logic              accept;
    logic [IDX_W-1:0]  idx_q;
    logic [TAG_W-1:0]  tag_q;
    logic              cach;
    logic [TAG_W-1:0]  stored;
    logic              vbit;
    logic              tag_match;
    lookup_t           lk;
    logic [TAG_W-1:0]  victim_tag;
    logic [ADDR_W-1:0] victim_addr;
    logic [TAG_W-1:0]  new_entry;
    logic              ram_we;
    logic [TAG_W-1:0]  ram_wd;
    logic              set_valid;

    assign split  = mode_split(mode);
    assign accept = (state_q == ST_IDLE) && !flush && req_valid;
    assign busy   = state_q != ST_IDLE;

    l2tc_addr_decode #(
        .ADDR_W(ADDR_W), .OFS_W(OFS_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) u_dec (
        .addr(addr_q), .split(split), .idx(idx_q), .tag(tag_q), .cacheable(cach)
    );

    l2tc_tag_ram #(.DEPTH(DEPTH), .AW(IDX_W), .DW(TAG_W)) u_tags (
        .clk(clk),
        .rd_en(accept),
        .rd_addr(req_addr[LINE_LO-1:OFS_W]),
        .rd_data(stored),
        .wr_en(ram_we),
        .wr_addr(idx_q),
        .wr_data(ram_wd)
    );

    l2tc_valid_array #(.DEPTH(DEPTH), .AW(IDX_W)) u_valid (
        .clk(clk),
        .rst(rst),
        .clr_en(state_q == ST_FLUSH),
        .clr_idx(flush_cnt_q),
        .set_en(set_valid),
        .set_idx(idx_q),
        .rd_idx(idx_q),
        .rd_valid(vbit)
    );

    // Lookup: the stored byte is compared over 7 or 8 bits per mode.
    always_comb begin
        if (split) tag_match = stored[TAG_W-2:0] == tag_q[TAG_W-2:0];
        else       tag_match = stored == tag_q;
        lk.hit          = cach && vbit && tag_match;
        lk.victim_dirty = victim_dirty(mode, vbit, stored[TAG_W-1]);
        victim_tag      = split ? {1'b0, stored[TAG_W-2:0]} : stored;
        victim_addr     = {{PAD_W{1'b0}}, victim_tag, idx_q, {OFS_W{1'b0}}};
        new_entry       = split ? {write_q, tag_q[TAG_W-2:0]} : tag_q;
    end

    // Tag store writes: dirty marking on a split-mode write hit, install on fill.
    always_comb begin
        set_valid = (state_q == ST_FILL) && fill_ack;
        ram_we    = set_valid ||
                    ((state_q == ST_LOOK) && lk.hit && write_q && split);
        ram_wd    = (state_q == ST_LOOK) ? {1'b1, tag_q[TAG_W-2:0]} : new_entry;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q        <= ST_IDLE;
            addr_q         <= '0;
            write_q        <= 1'b0;
            flush_cnt_q    <= '0;
            resp_valid     <= 1'b0;
            resp_hit       <= 1'b0;
            resp_cacheable <= 1'b0;
            mem_wr         <= 1'b0;
            wb_req         <= 1'b0;
            wb_addr        <= '0;
            fill_req       <= 1'b0;
            fill_addr      <= '0;
        end else begin
            resp_valid <= 1'b0;
            mem_wr     <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (flush) begin
                        state_q     <= ST_FLUSH;
                        flush_cnt_q <= '0;
                    end else if (req_valid) begin
                        addr_q  <= req_addr;
                        write_q <= req_write;
                        state_q <= ST_LOOK;
                    end
                end
                ST_LOOK: begin
                    resp_valid     <= 1'b1;
                    resp_hit       <= lk.hit;
                    resp_cacheable <= cach;
                    mem_wr         <= write_q && cach && mode_writethrough(mode);
                    fill_addr      <= {addr_q[ADDR_W-1:OFS_W], {OFS_W{1'b0}}};
                    if (!cach || lk.hit) begin
                        state_q <= ST_IDLE;
                    end else if (lk.victim_dirty) begin
                        wb_req  <= 1'b1;
                        wb_addr <= victim_addr;
                        state_q <= ST_WB;
                    end else begin
                        fill_req <= 1'b1;
                        state_q  <= ST_FILL;
                    end
                end
                ST_WB: begin
                    if (wb_ack) begin
                        wb_req   <= 1'b0;
                        fill_req <= 1'b1;
                        state_q  <= ST_FILL;
                    end
                end
                ST_FILL: begin
                    if (fill_ack) begin
                        fill_req <= 1'b0;
                        state_q  <= ST_IDLE;
                    end
                end
                ST_FLUSH: begin
                    if (flush_cnt_q == IDX_W'(DEPTH - 1)) state_q <= ST_IDLE;
                    else flush_cnt_q <= flush_cnt_q + 1'b1;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/l2_tag_ctrl_chk.sv
module l2_tag_ctrl_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              flush,
    input logic              req_valid,
    input logic              busy,
    input logic              resp_valid,
    input logic              resp_hit,
    input logic              resp_cacheable,
    input logic              mem_wr,
    input logic              wb_req,
    input logic [ADDR_W-1:0] wb_addr,
    input logic              wb_ack,
    input logic              fill_req,
    input logic [ADDR_W-1:0] fill_addr,
    input logic              fill_ack
);
    logic took_q;

    always_ff @(posedge clk) begin
        if (rst) took_q <= 1'b0;
        else     took_q <= req_valid && !flush && !busy;
    end

    AST_STROBE_ANSWERED: assert property (@(posedge clk) disable iff (rst)
        took_q |=> resp_valid);                                         // R1
    AST_RESP_SINGLE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid);                                    // R1
    AST_HIT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && resp_hit) |-> resp_cacheable);                   // R2
    AST_NC_NO_MEMOP: assert property (@(posedge clk) disable iff (rst)
        (resp_valid && !resp_cacheable) |-> (!fill_req && !wb_req));    // R2
    AST_FILL_HOLD: assert property (@(posedge clk) disable iff (rst)
        (fill_req && !fill_ack) |=> (fill_req && $stable(fill_addr)));  // R4
    AST_MEMOP_BUSY: assert property (@(posedge clk) disable iff (rst)
        (wb_req || fill_req) |-> busy);                                 // R4
    AST_REQ_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(wb_req && fill_req));                                         // R5
    AST_WB_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_addr)));          // R5
    AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
        (wb_req && wb_ack) |=> fill_req);                               // R5
    AST_WT_NO_WB: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd0 || mode == 2'd3) |-> !wb_req);                    // R7
    AST_MEMWR_WITH_RESP: assert property (@(posedge clk) disable iff (rst)
        mem_wr |-> (resp_valid && resp_cacheable));                     // R7
endmodule

bind l2_tag_ctrl l2_tag_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst(rst), .mode(mode), .flush(flush), .req_valid(req_valid),
    .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit),
    .resp_cacheable(resp_cacheable), .mem_wr(mem_wr), .wb_req(wb_req),
    .wb_addr(wb_addr), .wb_ack(wb_ack), .fill_req(fill_req),
    .fill_addr(fill_addr), .fill_ack(fill_ack)
);

// File: tb/l2_tag_ctrl_test.sv
module l2_tag_ctrl_test;
    localparam int AW    = 32;
    localparam int OFS   = 4;
    localparam int IDX   = 6;
    localparam int TAGW  = 8;
    localparam int DEPTH = 1 << IDX;
    localparam int LLO   = OFS + IDX;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [1:0]    mode = 2'd0;
    logic          flush = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic          busy, resp_valid, resp_hit, resp_cacheable, mem_wr;
    logic          wb_req, fill_req;
    logic [AW-1:0] wb_addr, fill_addr;
    logic          wb_ack = 1'b0;
    logic          fill_ack = 1'b0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic       exp_v [DEPTH];
    logic [7:0] exp_t [DEPTH];
    logic       exp_d [DEPTH];

    always #10 clk = ~clk;

    l2_tag_ctrl #(.ADDR_W(AW), .OFS_W(OFS), .IDX_W(IDX), .TAG_W(TAGW)) uut (
        .clk(clk), .rst(rst), .mode(mode), .flush(flush),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit),
        .resp_cacheable(resp_cacheable), .mem_wr(mem_wr),
        .wb_req(wb_req), .wb_addr(wb_addr), .wb_ack(wb_ack),
        .fill_req(fill_req), .fill_addr(fill_addr), .fill_ack(fill_ack)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int i = 0; i < DEPTH; i++) begin
            exp_v[i] = 1'b0;
            exp_t[i] = '0;
            exp_d[i] = 1'b0;
        end
    endtask

    task automatic access(input bit wr, input logic [31:0] a);
        int tb;
        bit cach, hit, dv, wt;
        int idx;
        logic [7:0] tg;
        logic [31:0] victim, line;
        tb     = (mode == 2'd1) ? 7 : 8;
        wt     = (mode == 2'd0) || (mode == 2'd3);
        cach   = (a >> (LLO + tb)) == 0;
        idx    = int'(a[LLO-1:OFS]);
        tg     = 8'((a >> LLO) & ((32'd1 << tb) - 1));
        hit    = cach && exp_v[idx] && (exp_t[idx] == tg);
        dv     = cach && !hit && exp_v[idx] &&
                 ((mode == 2'd1) ? exp_d[idx] : (mode == 2'd2));
        victim = (32'(exp_t[idx]) << LLO) | (32'(idx) << OFS);
        line   = a & ~32'((1 << OFS) - 1);

        req_valid = 1'b1; req_write = wr; req_addr = a;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R1", "busy during lookup", 32'(busy), 32'd1);
        chk("R1", "no early response", 32'(resp_valid), 32'd0);
        @(posedge clk); @(negedge clk);
        chk("R1", "resp_valid", 32'(resp_valid), 32'd1);
        chk("R2", "resp_cacheable", 32'(resp_cacheable), 32'(cach));
        chk("R3", "resp_hit", 32'(resp_hit), 32'(hit));
        chk("R7", "mem_wr", 32'(mem_wr), 32'(wr && cach && wt));
        if (cach && !hit) begin
            if (dv) begin
                chk(mode == 2'd1 ? "R5" : "R6", "wb_req", 32'(wb_req), 32'd1);
                chk(mode == 2'd1 ? "R5" : "R6", "wb_addr", wb_addr, victim);
                chk("R5", "no fill during wb", 32'(fill_req), 32'd0);
                @(posedge clk); @(negedge clk);
                chk("R5", "wb held", 32'(wb_req), 32'd1);
                wb_ack = 1'b1;
                @(posedge clk); @(negedge clk);
                wb_ack = 1'b0;
                chk("R5", "wb dropped", 32'(wb_req), 32'd0);
            end else begin
                chk(wt ? "R7" : "R4", "no wb", 32'(wb_req), 32'd0);
            end
            chk("R4", "fill_req", 32'(fill_req), 32'd1);
            chk("R4", "fill_addr", fill_addr, line);
            fill_ack = 1'b1;
            @(posedge clk); @(negedge clk);
            fill_ack = 1'b0;
            chk("R4", "fill dropped", 32'(fill_req), 32'd0);
            exp_v[idx] = 1'b1;
            exp_t[idx] = tg;
            exp_d[idx] = (mode == 2'd1) && wr;
        end else begin
            chk("R2", "no fill", 32'(fill_req), 32'd0);
            chk("R2", "no wb", 32'(wb_req), 32'd0);
            if (hit && wr && mode == 2'd1) exp_d[idx] = 1'b1;
        end
        chk("R1", "idle after access", 32'(busy), 32'd0);
    endtask

    task automatic do_flush();
        int n;
        bit saw;
        n = 0; saw = 1'b0;
        flush = 1'b1;
        @(posedge clk); @(negedge clk);
        flush = 1'b0;
        while (busy && n < 100000) begin
            n++;
            if (resp_valid) saw = 1'b1;
            req_valid = (n == 5);
            req_addr  = 32'h40;
            @(negedge clk);
        end
        req_valid = 1'b0;
        @(negedge clk);
        if (resp_valid) saw = 1'b1;
        chk("R8", "flush busy cycles", 32'(n), 32'(DEPTH));
        chk("R8", "strobe ignored in flush", 32'(saw), 32'd0);
        model_clear();
    endtask

    initial begin
        model_clear();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R9", "busy after reset", 32'(busy), 32'd0);
        chk("R9", "resp_valid after reset", 32'(resp_valid), 32'd0);
        chk("R9", "mem_wr after reset", 32'(mem_wr), 32'd0);
        chk("R9", "wb_req after reset", 32'(wb_req), 32'd0);
        chk("R9", "fill_req after reset", 32'(fill_req), 32'd0);
        access(1'b0, 32'h0000_0150);   // R9: every line invalid, so a miss

        for (int m = 0; m < 4; m++) begin
            int tb, lim;
            mode = 2'(m);
            tb   = (m == 1) ? 7 : 8;
            lim  = (m == 3) ? 8 : DEPTH;
            do_flush();
            for (int i = 0; i < lim; i++) begin
                logic [31:0] ta, tbb, a, b, nc;
                ta  = 32'((i * 37 + m * 11) & ((1 << tb) - 1));
                tbb = ta ^ 32'(1 + (i & 3));
                a   = (ta << LLO) | (32'(i) << OFS) | 32'(i & 15);
                b   = (tbb << LLO) | (32'(i) << OFS);
                nc  = a | (32'd1 << (LLO + tb)) | (32'(i & 1) << 31);
                access(1'b0, a);          // R4 miss and fill
                access(1'b0, a);          // R3 hit
                access(1'b1, a);          // R5/R7 write hit
                access(i[0], nc);         // R2 outside window
                access(i[1], b);          // R5/R6 replacement
                access(1'b0, b);          // R3 installed tag hits
                access(1'b0, a);          // R5/R6 replace again
            end
        end
        // R2 boundary: bit 17 set is cacheable in mode 0, not in mode 1.
        mode = 2'd0;
        do_flush();
        access(1'b0, 32'h0002_0030);
        access(1'b0, 32'h0002_0030);
        mode = 2'd1;
        do_flush();
        access(1'b1, 32'h0002_0030);
        access(1'b0, 32'h0001_fc30);
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 200000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog actual=running expected=finished");
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule